// File: doc/BRIEF.md
# Addressed Serial Frame Receiver

This block sits behind a byte-level UART receiver (8 data bits, one start bit, one stop bit, no parity). It watches the incoming byte stream for frames addressed to this node. A frame has a fixed layout: a device number, a function code, a byte count X, then X payload bytes, and finally a two-byte checksum. The device number and function code this node accepts are inputs, so one design serves every node on a shared bus.

The header is checked one byte at a time. When a header byte does not match, the parser drops the frame and starts looking for a new one. It does not wait for the rest of the frame to go by. The count byte gives the frame length, which is X plus five. Each payload byte is written out at once through an address/data/write-enable port, at offsets 0 to X-1. After the last checksum byte, a one-cycle pulse reports the result. A good pulse tells the consumer to commit what it stored. An error pulse tells it to throw the frame away. If the stream stalls partway through a frame, the parser gives up on that frame.

Top module: `frame_rx`

## Requirements
- R1: While and right after synchronous reset, buf_we, frame_ok and frame_err are low and the parser is waiting for a frame start.
- R2: A first byte that differs from my_dev starts no frame: no buffer write and no result pulse follow from it.
- R3: If the byte after a matching device number differs from my_func, the frame is dropped at once, and the very next byte is examined as a possible device number.
- R4: The third byte is the payload count X. The k-th payload byte (k from 0) appears on buf_data with buf_addr = k and buf_we high for one cycle, in the cycle after that byte is accepted. A frame produces exactly X writes and is X + 5 bytes long.
- R5: The checksum is CRC-16 with reflected polynomial 0xA001 and initial value 0xFFFF, computed over the three header bytes and the payload and sent low byte first. If the received value matches, frame_ok is high for one cycle, in the cycle after the final byte.
- R6: If the received checksum does not match, frame_err is high for one cycle in the cycle after the final byte, and frame_ok stays low.
- R7: A frame with X = 0 makes no buffer writes. Its two checksum bytes follow the count byte directly.
- R8: If a frame has started and no byte arrives for TIMEOUT_CYC cycles, the parser returns to waiting for a device number, with no result pulse. A complete frame sent afterwards is received correctly.
- R9: frame_ok and frame_err are never high in the same cycle, and neither stays high for two cycles in a row.
- R10: Idle cycles between bytes (rx_valid low), fewer than TIMEOUT_CYC, do not change how a frame is parsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| my_dev | input | 8 | Device number this node answers to |
| my_func | input | 8 | Function code this node accepts |
| buf_addr | output | 8 | Payload offset of the byte being written |
| buf_data | output | 8 | Payload byte being written |
| buf_we | output | 1 | Write strobe for the buffer port |
| frame_ok | output | 1 | One-cycle pulse: frame complete, checksum matched |
| frame_err | output | 1 | One-cycle pulse: frame complete, checksum mismatched |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:

- **Zero-length frame.** A parser that does not special-case X = 0 would take the checksum bytes as payload.
- **Bad function code followed at once by a good frame.** A parser that resynchronises late would lose the good frame.
- **Stalled frame followed by a fresh one.** Without the timeout, the fresh frame's bytes would be swallowed as leftover payload, and the result would be a checksum error instead of success.
- **Corrupted checksum and frames from another device number.** A design whose checksum, byte order or address filter is wrong would pulse frame_ok for frames it must reject.

Random frame lengths, random payloads and random gaps between bytes are mixed with these directed cases.

// File: rtl/fr_pkg.sv
package fr_pkg;

  localparam int          BYTE_W   = 8;
  localparam logic [15:0] CRC_POLY = 16'hA001;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FUNC,
    S_LEN,
    S_PAY,
    S_CRCLO,
    S_CRCHI
  } fr_state_t;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c_in,
                                             input logic [BYTE_W-1:0] d);
    logic [15:0] c;
    c = c_in ^ {8'h00, d};
    for (int i = 0; i < 8; i++) begin
      if (c[0]) c = (c >> 1) ^ CRC_POLY;
      else      c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/fr_crc16.sv
module fr_crc16
  import fr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [15:0]       crc
);

  logic [15:0] base;

  always_comb base = start ? CRC_INIT : crc;

  always_ff @(posedge clk) begin
    if (rst)     crc <= CRC_INIT;
    else if (en) crc <= crc16_byte(base, din);
  end

endmodule

// File: rtl/fr_gap_timer.sv
module fr_gap_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  output logic expire
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_comb expire = active && !tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active || tick) cnt <= '0;
    else if (cnt != LAST)       cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import fr_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  input  logic [7:0] my_dev,
  input  logic [7:0] my_func,
  output logic [7:0] buf_addr,
  output logic [7:0] buf_data,
  output logic       buf_we,
  output logic       frame_ok,
  output logic       frame_err
);

  fr_state_t   st;
  logic [7:0]  len_q;
  logic [7:0]  idx_q;
  logic [7:0]  lo_q;
  logic [15:0] crc;
  logic        crc_en;
  logic        crc_start;
  logic        tmo;

  always_comb begin
    crc_start = (st == S_IDLE);
    crc_en    = rx_valid && (((st == S_IDLE) && (rx_data == my_dev)) ||
                             (st == S_FUNC) || (st == S_LEN) || (st == S_PAY));
  end

  fr_crc16 u_crc (
    .clk   (clk),
    .rst   (rst),
    .start (crc_start),
    .en    (crc_en),
    .din   (rx_data),
    .crc   (crc)
  );

  fr_gap_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .active (st != S_IDLE),
    .tick   (rx_valid),
    .expire (tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      len_q     <= '0;
      idx_q     <= '0;
      lo_q      <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_data  <= '0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      buf_we    <= 1'b0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      if (rx_valid) begin
        case (st)
          S_IDLE:  if (rx_data == my_dev) st <= S_FUNC;
          S_FUNC:  st <= (rx_data == my_func) ? S_LEN : S_IDLE;
          S_LEN: begin
            len_q <= rx_data;
            idx_q <= '0;
            st    <= (rx_data == 8'd0) ? S_CRCLO : S_PAY;
          end
          S_PAY: begin
            buf_we   <= 1'b1;
            buf_addr <= idx_q;
            buf_data <= rx_data;
            idx_q    <= idx_q + 1'b1;
            if (idx_q == len_q - 1'b1) st <= S_CRCLO;
          end
          S_CRCLO: begin
            lo_q <= rx_data;
            st   <= S_CRCHI;
          end
          S_CRCHI: begin
            if ({rx_data, lo_q} == crc) frame_ok  <= 1'b1;
            else                        frame_err <= 1'b1;
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end else if (tmo) begin
        st <= S_IDLE;
      end
    end
  end

  AST_WE_FROM_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> ($past(st) == S_PAY) && $past(rx_valid)); // R4
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (buf_addr < len_q)); // R4
  AST_RESULT_AFTER_CRC: assert property (@(posedge clk) disable iff (rst)
    (frame_ok || frame_err) |-> ($past(st) == S_CRCHI) && $past(rx_valid)); // R5
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(frame_ok && frame_err)); // R9
  AST_OK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> !frame_ok); // R9
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    tmo |=> (st == S_IDLE)); // R8

endmodule

// File: tb/frame_rx_test.sv
module frame_rx_test;

  localparam int TMO = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic [7:0] my_dev = 8'h11;
  logic [7:0] my_func = 8'h03;
  logic [7:0] buf_addr, buf_data;
  logic       buf_we, frame_ok, frame_err;

  frame_rx #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .my_dev(my_dev), .my_func(my_func), .buf_addr(buf_addr),
    .buf_data(buf_data), .buf_we(buf_we), .frame_ok(frame_ok),
    .frame_err(frame_err)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int n_wr = 0, n_ok = 0, n_err = 0, n_both = 0, n_long = 0;
  logic prev_ok = 1'b0, prev_err = 1'b0;
  logic [7:0] seen [0:255];
  logic [7:0] fb [0:63];
  int flen;

  always @(negedge clk) begin
    if (!rst) begin
      if (buf_we) begin
        seen[buf_addr] = buf_data;
        n_wr++;
      end
      if (frame_ok) n_ok++;
      if (frame_err) n_err++;
      if (frame_ok && frame_err) n_both++;
      if ((frame_ok && prev_ok) || (frame_err && prev_err)) n_long++;
      prev_ok = frame_ok;
      prev_err = frame_err;
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int k);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < k; i++) begin
      c = c ^ {8'h00, fb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  task automatic build(input logic [7:0] dev, input logic [7:0] func, input int n,
                       input bit rnd, input bit corrupt);
    logic [15:0] c;
    fb[0] = dev;
    fb[1] = func;
    fb[2] = n[7:0];
    for (int i = 0; i < n; i++) fb[3 + i] = rnd ? 8'($urandom) : 8'(8'h40 + i);
    c = ref_crc(n + 3);
    if (corrupt) c = c ^ 16'h0100;
    fb[n + 3] = c[7:0];
    fb[n + 4] = c[15:8];
    flen = n + 5;
  endtask

  task automatic send(input logic [7:0] b, input int gap);
    rx_data = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_frame(input int maxgap);
    for (int i = 0; i < flen; i++) send(fb[i], (maxgap == 0) ? 0 : int'($urandom % (maxgap + 1)));
  endtask

  task automatic expect_result(input string req, input int n, input bit good,
                               input int b_wr, input int b_ok, input int b_err);
    int bad = 0;
    repeat (3) @(negedge clk);
    chk((n_ok - b_ok) == int'(good), req, n_ok - b_ok, int'(good));
    chk((n_err - b_err) == int'(!good), req, n_err - b_err, int'(!good));
    chk((n_wr - b_wr) == n, req, n_wr - b_wr, n);
    if (good) begin
      for (int i = 0; i < n; i++) if (seen[i] !== fb[3 + i]) bad++;
      chk(bad == 0, req, bad, 0);
    end
  endtask

  task automatic run_frame(input string req, input int n, input bit rnd,
                           input bit corrupt, input int maxgap);
    int b_wr = n_wr, b_ok = n_ok, b_err = n_err;
    build(my_dev, my_func, n, rnd, corrupt);
    send_frame(maxgap);
    expect_result(req, n, !corrupt, b_wr, b_ok, b_err);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int b_wr, b_ok, b_err;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1: outputs idle during and just after reset
    chk(!buf_we && !frame_ok && !frame_err, "R1", int'(buf_we | frame_ok | frame_err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!buf_we && !frame_ok && !frame_err, "R1", int'(buf_we | frame_ok | frame_err), 0);

    run_frame("R4/R5 four-byte frame", 4, 1'b0, 1'b0, 0);
    run_frame("R7 empty frame", 0, 1'b0, 1'b0, 0);
    run_frame("R4 one-byte frame", 1, 1'b1, 1'b0, 0);
    run_frame("R6 corrupted checksum", 6, 1'b0, 1'b1, 0);

    // R2: another device's frame leaves no trace
    b_wr = n_wr; b_ok = n_ok; b_err = n_err;
    build(8'h12, my_func, 5, 1'b0, 1'b0);
    send_frame(0);
    repeat (TMO + 10) @(negedge clk);
    chk(n_wr == b_wr && n_ok == b_ok && n_err == b_err, "R2 foreign device",
        (n_wr - b_wr) + (n_ok - b_ok) + (n_err - b_err), 0);

    // R3: wrong function code, then a good frame with no pause
    b_wr = n_wr; b_ok = n_ok; b_err = n_err;
    send(my_dev, 0);
    send(8'h02, 0);
    build(my_dev, my_func, 3, 1'b1, 1'b0);
    send_frame(0);
    expect_result("R3 restart after bad function", 3, 1'b1, b_wr, b_ok, b_err);

    // R8: stalled frame abandoned, next frame parsed cleanly
    b_wr = n_wr; b_ok = n_ok; b_err = n_err;
    send(my_dev, 0);
    send(my_func, 0);
    send(8'd5, 0);
    send(8'hAA, 0);
    send(8'hBB, 0);
    repeat (TMO + 20) @(negedge clk);
    chk(n_ok == b_ok && n_err == b_err, "R8 no pulse on stall", n_ok + n_err - b_ok - b_err, 0);
    b_wr = n_wr;
    run_frame("R8 frame after timeout", 4, 1'b1, 1'b0, 0);

    run_frame("R10 gapped bytes", 7, 1'b1, 1'b0, 3);
    run_frame("R4 long frame", 40, 1'b1, 1'b0, 1);

    for (int f = 0; f < 20; f++) begin
      run_frame("R5/R6/R10 random frame", int'($urandom % 24), 1'b1,
                ($urandom % 4) == 0, int'($urandom % 3));
    end

    chk(n_both == 0, "R9 simultaneous pulses", n_both, 0);
    chk(n_long == 0, "R9 stretched pulse", n_long, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule